// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the byte-wide arithmetic and logic unit of an accumulator-oriented microcontroller core. Each clock it takes the accumulator, a second operand byte, the B register, the incoming carry and auxiliary-carry flags and a 5-bit operation code. It then computes a new accumulator, a new B value and the carry (CY), auxiliary-carry (AC) and overflow (OV) flags. Each flag comes with its own write-enable, so the status word outside the block changes only the flags that the operation defines.

Every result is registered. Whatever is presented on the inputs before a rising edge appears on the outputs right after that edge, so the latency is one cycle. Multiply and divide finish in the same single cycle as the simpler operations. Register files and operand fetch sit outside the block.

Top module: `acc_alu`

## Requirements
- R1: Outputs are registered with one cycle of latency. While `rst` is high at a rising edge, all outputs, including the three flag enables, become 0.
- R2: Op 0 (add) computes A+operand and op 1 (add with carry) computes A+operand+CY. CY is the carry out of bit 7, AC is the carry out of bit 3, and OV is the carry into bit 7 XOR the carry out of bit 7. All three enables are 1.
- R3: Op 2 (subtract with borrow) computes A−operand−CY. CY is the borrow out of bit 7 and AC is the borrow out of bit 3. OV is the borrow into bit 7 XOR the borrow out of bit 7. All three enables are 1.
- R4: Op 3 (increment) and op 4 (decrement) wrap at FFh and 00h and raise no flag enable.
- R5: Op 5 (multiply) gives A×B, with the low byte in A and the high byte in B. OV=1 exactly when the high byte is non-zero, and CY=0. The CY and OV enables are 1 and the AC enable is 0.
- R6: Op 6 (divide) with B≠0 gives the quotient of A/B in A and the remainder in B, with CY=0 and OV=0. The CY and OV enables are 1.
- R7: Op 6 with B=00h sets OV=1 and CY=0, with the CY and OV enables at 1. A and B keep their input values.
- R8: Op 7 (decimal adjust) adds 06h when the low nibble is above 9 or AC=1. It then adds 60h when the high nibble is above 9, when CY=1, or when the first addition carried. CY becomes 1 if CY was already 1 or if either addition carried, otherwise 0. Only the CY enable is 1.
- R9: Ops 8 AND, 9 OR and 10 XOR combine A with the operand. Op 11 clears A, op 12 inverts A and op 17 exchanges the nibbles of A. None of them raises a flag enable.
- R10: Op 13 rotates A left by one and op 15 rotates A right by one, without going through the carry. Neither raises a flag enable.
- R11: Op 14 rotates left through the carry and op 16 rotates right through the carry. Bit 7 (left) or bit 0 (right) goes to CY, the old CY fills the vacated bit, and only the CY enable is 1.
- R12: Every op other than 5 and 6 passes B through unchanged. Op codes 18 to 31 pass A through and raise no flag enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 5 | Operation code |
| acc_in | input | 8 | Current accumulator |
| opnd_in | input | 8 | Second operand byte |
| b_in | input | 8 | Current B register |
| cy_in | input | 1 | Current carry flag |
| ac_in | input | 1 | Current auxiliary-carry flag |
| acc_out | output | 8 | New accumulator |
| b_out | output | 8 | New B register |
| cy_out | output | 1 | New carry flag |
| cy_we | output | 1 | Carry flag write-enable |
| ac_out | output | 1 | New auxiliary-carry flag |
| ac_we | output | 1 | Auxiliary-carry write-enable |
| ov_out | output | 1 | New overflow flag |
| ov_we | output | 1 | Overflow write-enable |

## Verification
The assertions assume that every input is driven to a known value at each rising edge while reset is low. Each property looks only at the operation code and operands of the previous cycle, so it also assumes that no input changes close to the edge. The stimulus meets both conditions: it drives every input from time zero, changes inputs only on falling edges, and holds reset high through the first edges. Op codes outside the defined set are applied on purpose, because the pass-through rule also covers them.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int DW   = 8;
  localparam int NW   = DW / 2;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,  OP_ADDC = 5'd1,  OP_SUBB = 5'd2,  OP_INC  = 5'd3,
    OP_DEC  = 5'd4,  OP_MUL  = 5'd5,  OP_DIV  = 5'd6,  OP_DA   = 5'd7,
    OP_AND  = 5'd8,  OP_OR   = 5'd9,  OP_XOR  = 5'd10, OP_CLR  = 5'd11,
    OP_CPL  = 5'd12, OP_RL   = 5'd13, OP_RLC  = 5'd14, OP_RR   = 5'd15,
    OP_RRC  = 5'd16, OP_SWAP = 5'd17
  } alu_op_e;

  typedef struct packed {
    logic [DW-1:0] acc;
    logic [DW-1:0] b;
    logic          cy;
    logic          cy_we;
    logic          ac;
    logic          ac_we;
    logic          ov;
    logic          ov_we;
  } alu_res_t;
endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
  import acc_alu_pkg::*;
(
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] o,
  input  logic [DW-1:0] b,
  input  logic          cy_in,
  input  logic          ac_in,
  output alu_res_t      res,
  output logic          hit
);
  localparam logic [NW-1:0] NINE   = NW'(9);
  localparam logic [DW:0]   ADJ_LO = (DW+1)'(6);
  localparam logic [DW:0]   ADJ_HI = ADJ_LO << NW;
  localparam logic [DW-1:0] ONE    = DW'(1);

  logic          cin;
  logic [DW:0]   sum, dif;
  logic [NW:0]   nsum, ndif;
  logic [DW-1:0] lsum, ldif;
  logic          lo_fix, hi_fix;
  logic [DW:0]   da1, da2;

  always_comb begin
    cin  = (op == OP_ADDC) ? cy_in : 1'b0;
    sum  = {1'b0, a} + {1'b0, o} + {{DW{1'b0}}, cin};
    nsum = {1'b0, a[NW-1:0]} + {1'b0, o[NW-1:0]} + {{NW{1'b0}}, cin};
    lsum = {1'b0, a[DW-2:0]} + {1'b0, o[DW-2:0]} + {{(DW-1){1'b0}}, cin};
    dif  = {1'b0, a} - {1'b0, o} - {{DW{1'b0}}, cy_in};
    ndif = {1'b0, a[NW-1:0]} - {1'b0, o[NW-1:0]} - {{NW{1'b0}}, cy_in};
    ldif = {1'b0, a[DW-2:0]} - {1'b0, o[DW-2:0]} - {{(DW-1){1'b0}}, cy_in};
    // decimal adjust: two chained corrections
    lo_fix = (a[NW-1:0] > NINE) || ac_in;
    da1    = {1'b0, a} + (lo_fix ? ADJ_LO : '0);
    hi_fix = (da1[DW-1:DW-NW] > NINE) || cy_in || da1[DW];
    da2    = {1'b0, da1[DW-1:0]} + (hi_fix ? ADJ_HI : '0);
  end

  always_comb begin
    res     = '0;
    res.acc = a;
    res.b   = b;
    res.cy  = cy_in;
    res.ac  = ac_in;
    hit     = 1'b1;
    case (op)
      OP_ADD, OP_ADDC: begin
        res.acc = sum[DW-1:0];
        res.cy  = sum[DW];
        res.ac  = nsum[NW];
        res.ov  = lsum[DW-1] ^ sum[DW];
        res.cy_we = 1'b1; res.ac_we = 1'b1; res.ov_we = 1'b1;
      end
      OP_SUBB: begin
        res.acc = dif[DW-1:0];
        res.cy  = dif[DW];
        res.ac  = ndif[NW];
        res.ov  = ldif[DW-1] ^ dif[DW];
        res.cy_we = 1'b1; res.ac_we = 1'b1; res.ov_we = 1'b1;
      end
      OP_INC: res.acc = a + ONE;
      OP_DEC: res.acc = a - ONE;
      OP_DA: begin
        res.acc   = da2[DW-1:0];
        res.cy    = cy_in | da1[DW] | da2[DW];
        res.cy_we = 1'b1;
      end
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_alu_muldiv.sv
module acc_alu_muldiv
  import acc_alu_pkg::*;
(
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cy_in,
  input  logic          ac_in,
  output alu_res_t      res,
  output logic          hit
);
  logic [2*DW-1:0] prod;
  logic [DW:0]     rem;
  logic [DW-1:0]   quo;

  // restoring division, one trial subtraction per quotient bit
  always_comb begin
    prod = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
    rem  = '0;
    quo  = '0;
    for (int i = DW - 1; i >= 0; i--) begin
      rem = {rem[DW-1:0], a[i]};
      if (rem >= {1'b0, b}) begin
        rem    = rem - {1'b0, b};
        quo[i] = 1'b1;
      end
    end
  end

  always_comb begin
    res     = '0;
    res.acc = a;
    res.b   = b;
    res.cy  = cy_in;
    res.ac  = ac_in;
    hit     = 1'b1;
    case (op)
      OP_MUL: begin
        res.acc   = prod[DW-1:0];
        res.b     = prod[2*DW-1:DW];
        res.cy    = 1'b0;
        res.ov    = |prod[2*DW-1:DW];
        res.cy_we = 1'b1;
        res.ov_we = 1'b1;
      end
      OP_DIV: begin
        res.cy    = 1'b0;
        res.cy_we = 1'b1;
        res.ov_we = 1'b1;
        if (b == '0) begin
          res.ov = 1'b1;
        end else begin
          res.acc = quo;
          res.b   = rem[DW-1:0];
          res.ov  = 1'b0;
        end
      end
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
  import acc_alu_pkg::*;
(
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] o,
  input  logic [DW-1:0] b,
  input  logic          cy_in,
  input  logic          ac_in,
  output alu_res_t      res,
  output logic          hit
);
  always_comb begin
    res     = '0;
    res.acc = a;
    res.b   = b;
    res.cy  = cy_in;
    res.ac  = ac_in;
    hit     = 1'b1;
    case (op)
      OP_AND:  res.acc = a & o;
      OP_OR:   res.acc = a | o;
      OP_XOR:  res.acc = a ^ o;
      OP_CLR:  res.acc = '0;
      OP_CPL:  res.acc = ~a;
      OP_SWAP: res.acc = {a[NW-1:0], a[DW-1:NW]};
      OP_RL:   res.acc = {a[DW-2:0], a[DW-1]};
      OP_RR:   res.acc = {a[0], a[DW-1:1]};
      OP_RLC: begin
        res.acc   = {a[DW-2:0], cy_in};
        res.cy    = a[DW-1];
        res.cy_we = 1'b1;
      end
      OP_RRC: begin
        res.acc   = {cy_in, a[DW-1:1]};
        res.cy    = a[0];
        res.cy_we = 1'b1;
      end
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] op,
  input  logic [DW-1:0]   acc_in,
  input  logic [DW-1:0]   opnd_in,
  input  logic [DW-1:0]   b_in,
  input  logic            cy_in,
  input  logic            ac_in,
  output logic [DW-1:0]   acc_out,
  output logic [DW-1:0]   b_out,
  output logic            cy_out,
  output logic            cy_we,
  output logic            ac_out,
  output logic            ac_we,
  output logic            ov_out,
  output logic            ov_we
);
  alu_op_e  opc;
  alu_res_t ar_res, md_res, bo_res, nxt, q;
  logic     ar_hit, md_hit, bo_hit;

  assign opc = alu_op_e'(op);

  acc_alu_arith u_arith (
    .op(opc), .a(acc_in), .o(opnd_in), .b(b_in),
    .cy_in(cy_in), .ac_in(ac_in), .res(ar_res), .hit(ar_hit)
  );

  acc_alu_muldiv u_muldiv (
    .op(opc), .a(acc_in), .b(b_in),
    .cy_in(cy_in), .ac_in(ac_in), .res(md_res), .hit(md_hit)
  );

  acc_alu_bitops u_bitops (
    .op(opc), .a(acc_in), .o(opnd_in), .b(b_in),
    .cy_in(cy_in), .ac_in(ac_in), .res(bo_res), .hit(bo_hit)
  );

  always_comb begin
    if (ar_hit)      nxt = ar_res;
    else if (md_hit) nxt = md_res;
    else if (bo_hit) nxt = bo_res;
    else begin
      nxt     = '0;
      nxt.acc = acc_in;
      nxt.b   = b_in;
      nxt.cy  = cy_in;
      nxt.ac  = ac_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  assign acc_out = q.acc;
  assign b_out   = q.b;
  assign cy_out  = q.cy;
  assign cy_we   = q.cy_we;
  assign ac_out  = q.ac;
  assign ac_we   = q.ac_we;
  assign ov_out  = q.ov;
  assign ov_we   = q.ov_we;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (acc_out == '0 && b_out == '0 && !cy_we && !ac_we && !ov_we));

  a_r4_inc_wraps: assert property (@(posedge clk) disable iff (rst)
    (op == OP_INC) |=> (acc_out == $past(acc_in) + DW'(1) && !cy_we && !ac_we && !ov_we));

  a_r5_mul_flags: assert property (@(posedge clk) disable iff (rst)
    (op == OP_MUL) |=> (cy_we && !cy_out && ov_we && !ac_we));

  a_r7_div_zero: assert property (@(posedge clk) disable iff (rst)
    (op == OP_DIV && b_in == '0) |=> (ov_we && ov_out && cy_we && !cy_out));

  a_r8_da_keeps_carry: assert property (@(posedge clk) disable iff (rst)
    (op == OP_DA && cy_in) |=> (cy_we && cy_out && !ac_we && !ov_we));

  a_r9_logic_no_flags: assert property (@(posedge clk) disable iff (rst)
    (opc inside {OP_AND, OP_OR, OP_XOR, OP_CLR, OP_CPL, OP_SWAP}) |=> (!cy_we && !ac_we && !ov_we));

  a_r12_b_held: assert property (@(posedge clk) disable iff (rst)
    !(op == OP_MUL || op == OP_DIV) |=> (b_out == $past(b_in)));
endmodule

// File: tb/acc_alu_test.sv
`timescale 1ns/1ps
module acc_alu_test;
  typedef struct packed {
    logic [4:0] op;
    logic [7:0] a, o, b;
    logic       cy, ac;
    logic [7:0] ea, eb;
    logic [5:0] fl;   // {cy_we, cy, ac_we, ac, ov_we, ov}
    logic       chkb;
    logic [3:0] rq;
  } vec_t;

  function automatic vec_t mk(input logic [4:0] op, input logic [7:0] a, o, b,
                              input logic cy, ac, input logic [7:0] ea, eb,
                              input logic [5:0] fl, input logic chkb, input logic [3:0] rq);
    return '{op, a, o, b, cy, ac, ea, eb, fl, chkb, rq};
  endfunction

  localparam int NV = 30;
  localparam vec_t TBL [NV] = '{
    mk(5'd0,  8'h7F, 8'h01, 8'h5A, 1'b0, 1'b0, 8'h80, 8'h5A, 6'b101111, 1'b1, 4'd2),  // R2
    mk(5'd0,  8'hFF, 8'h01, 8'h5A, 1'b1, 1'b0, 8'h00, 8'h5A, 6'b111110, 1'b1, 4'd2),  // R2 carry in ignored
    mk(5'd1,  8'h3A, 8'h05, 8'h5A, 1'b1, 1'b0, 8'h40, 8'h5A, 6'b101110, 1'b1, 4'd2),  // R2
    mk(5'd2,  8'hC9, 8'h54, 8'h5A, 1'b1, 1'b0, 8'h74, 8'h5A, 6'b101011, 1'b1, 4'd3),  // R3
    mk(5'd2,  8'h10, 8'h20, 8'h5A, 1'b0, 1'b1, 8'hF0, 8'h5A, 6'b111010, 1'b1, 4'd3),  // R3
    mk(5'd2,  8'h80, 8'h01, 8'h5A, 1'b0, 1'b0, 8'h7F, 8'h5A, 6'b101111, 1'b1, 4'd3),  // R3
    mk(5'd3,  8'hFF, 8'h00, 8'h5A, 1'b1, 1'b1, 8'h00, 8'h5A, 6'b000000, 1'b1, 4'd4),  // R4
    mk(5'd4,  8'h00, 8'h00, 8'h5A, 1'b1, 1'b1, 8'hFF, 8'h5A, 6'b000000, 1'b1, 4'd4),  // R4
    mk(5'd5,  8'h55, 8'h00, 8'h17, 1'b1, 1'b0, 8'hA3, 8'h07, 6'b100011, 1'b1, 4'd5),  // R5
    mk(5'd5,  8'h0F, 8'h00, 8'h10, 1'b1, 1'b0, 8'hF0, 8'h00, 6'b100010, 1'b1, 4'd5),  // R5
    mk(5'd6,  8'h5A, 8'h00, 8'h05, 1'b1, 1'b0, 8'h12, 8'h00, 6'b100010, 1'b1, 4'd6),  // R6
    mk(5'd6,  8'hFF, 8'h00, 8'h10, 1'b0, 1'b0, 8'h0F, 8'h0F, 6'b100010, 1'b1, 4'd6),  // R6
    mk(5'd6,  8'h07, 8'h00, 8'h09, 1'b0, 1'b0, 8'h00, 8'h07, 6'b100010, 1'b1, 4'd6),  // R6
    mk(5'd6,  8'h33, 8'h00, 8'h00, 1'b1, 1'b0, 8'h33, 8'h00, 6'b100011, 1'b1, 4'd7),  // R7
    mk(5'd7,  8'h81, 8'h00, 8'h5A, 1'b0, 1'b1, 8'h87, 8'h5A, 6'b100000, 1'b1, 4'd8),  // R8
    mk(5'd7,  8'h9A, 8'h00, 8'h5A, 1'b0, 1'b0, 8'h00, 8'h5A, 6'b110000, 1'b1, 4'd8),  // R8
    mk(5'd7,  8'h00, 8'h00, 8'h5A, 1'b1, 1'b0, 8'h60, 8'h5A, 6'b110000, 1'b1, 4'd8),  // R8 sticky carry
    mk(5'd7,  8'h12, 8'h00, 8'h5A, 1'b0, 1'b0, 8'h12, 8'h5A, 6'b100000, 1'b1, 4'd8),  // R8
    mk(5'd8,  8'hD3, 8'h75, 8'h5A, 1'b1, 1'b1, 8'h51, 8'h5A, 6'b000000, 1'b1, 4'd9),  // R9
    mk(5'd9,  8'hD3, 8'h75, 8'h5A, 1'b1, 1'b1, 8'hF7, 8'h5A, 6'b000000, 1'b1, 4'd9),  // R9
    mk(5'd10, 8'hC3, 8'hAA, 8'h5A, 1'b1, 1'b1, 8'h69, 8'h5A, 6'b000000, 1'b1, 4'd9),  // R9
    mk(5'd11, 8'hC3, 8'h00, 8'h5A, 1'b1, 1'b1, 8'h00, 8'h5A, 6'b000000, 1'b1, 4'd9),  // R9
    mk(5'd12, 8'hC3, 8'h00, 8'h5A, 1'b1, 1'b1, 8'h3C, 8'h5A, 6'b000000, 1'b1, 4'd9),  // R9
    mk(5'd17, 8'hC3, 8'h00, 8'h5A, 1'b1, 1'b1, 8'h3C, 8'h5A, 6'b000000, 1'b1, 4'd9),  // R9
    mk(5'd13, 8'hC3, 8'h00, 8'h5A, 1'b0, 1'b0, 8'h87, 8'h5A, 6'b000000, 1'b1, 4'd10), // R10
    mk(5'd15, 8'hC3, 8'h00, 8'h5A, 1'b1, 1'b0, 8'hE1, 8'h5A, 6'b000000, 1'b1, 4'd10), // R10
    mk(5'd14, 8'hC3, 8'h00, 8'h5A, 1'b1, 1'b0, 8'h87, 8'h5A, 6'b110000, 1'b1, 4'd11), // R11
    mk(5'd16, 8'hC3, 8'h00, 8'h5A, 1'b0, 1'b0, 8'h61, 8'h5A, 6'b110000, 1'b1, 4'd11), // R11
    mk(5'd14, 8'h40, 8'h00, 8'h5A, 1'b0, 1'b0, 8'h80, 8'h5A, 6'b100000, 1'b1, 4'd11), // R11
    mk(5'd31, 8'h5C, 8'h11, 8'hA5, 1'b1, 1'b1, 8'h5C, 8'hA5, 6'b000000, 1'b1, 4'd12)  // R12
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] op = '0;
  logic [7:0] acc_in = '0, opnd_in = '0, b_in = '0;
  logic       cy_in = 1'b0, ac_in = 1'b0;
  logic [7:0] acc_out, b_out;
  logic       cy_out, cy_we, ac_out, ac_we, ov_out, ov_we;
  int         checks = 0;
  int         fails = 0;

  always #2.5 clk = ~clk;

  acc_alu uut (
    .clk(clk), .rst(rst), .op(op), .acc_in(acc_in), .opnd_in(opnd_in),
    .b_in(b_in), .cy_in(cy_in), .ac_in(ac_in), .acc_out(acc_out), .b_out(b_out),
    .cy_out(cy_out), .cy_we(cy_we), .ac_out(ac_out), .ac_we(ac_we),
    .ov_out(ov_out), .ov_we(ov_we)
  );

  task automatic chk(input string what, input int rq, input logic [15:0] got, exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d %s: got %h expected %h", rq, what, got, exp);
    end
  endtask

  task automatic drive(input logic [4:0] p, input logic [7:0] a, o, b, input logic c, h);
    op = p; acc_in = a; opnd_in = o; b_in = b; cy_in = c; ac_in = h;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    drive(5'd0, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("reset acc", 1, {8'h0, acc_out}, 16'h0);
    chk("reset enables", 1, {13'h0, cy_we, ac_we, ov_we}, 16'h0);
    rst = 1'b0;

    foreach (TBL[i]) begin
      drive(TBL[i].op, TBL[i].a, TBL[i].o, TBL[i].b, TBL[i].cy, TBL[i].ac);
      @(negedge clk);
      chk("acc", TBL[i].rq, {8'h0, acc_out}, {8'h0, TBL[i].ea});
      if (TBL[i].chkb) chk("b", TBL[i].rq, {8'h0, b_out}, {8'h0, TBL[i].eb});
      chk("enables", TBL[i].rq, {13'h0, cy_we, ac_we, ov_we},
          {13'h0, TBL[i].fl[5], TBL[i].fl[3], TBL[i].fl[1]});
      if (TBL[i].fl[5]) chk("cy", TBL[i].rq, {15'h0, cy_out}, {15'h0, TBL[i].fl[4]});
      if (TBL[i].fl[3]) chk("ac", TBL[i].rq, {15'h0, ac_out}, {15'h0, TBL[i].fl[2]});
      if (TBL[i].fl[1]) chk("ov", TBL[i].rq, {15'h0, ov_out}, {15'h0, TBL[i].fl[0]});
    end

    // R1: one cycle of latency; output keeps the previous result until the edge
    drive(5'd0, 8'h01, 8'h01, 8'h00, 1'b0, 1'b0);
    @(negedge clk);
    chk("latency first", 1, {8'h0, acc_out}, 16'h0002);
    drive(5'd3, 8'h41, 8'h00, 8'h00, 1'b0, 1'b0);
    #1;
    chk("latency hold", 1, {8'h0, acc_out}, 16'h0002);
    @(negedge clk);
    chk("latency update", 1, {8'h0, acc_out}, 16'h0042);

    // R12: another undefined code right after a flag-writing op
    drive(5'd2, 8'h00, 8'h01, 8'h33, 1'b0, 1'b0);
    @(negedge clk);
    drive(5'd18, 8'hE7, 8'h00, 8'h3C, 1'b1, 1'b0);
    @(negedge clk);
    chk("undefined acc", 12, {8'h0, acc_out}, 16'h00E7);
    chk("undefined b", 12, {8'h0, b_out}, 16'h003C);
    chk("undefined enables", 12, {13'h0, cy_we, ac_we, ov_we}, 16'h0);

    // R1: reset asserted mid-run clears a non-zero result
    drive(5'd5, 8'hFF, 8'h00, 8'hFF, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("mid reset acc", 1, {b_out, acc_out}, 16'h0);
    chk("mid reset enables", 1, {13'h0, cy_we, ac_we, ov_we}, 16'h0);
    rst = 1'b0;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule